// File: doc/BRIEF.md
# Metastability Entropy Harvest Controller

This block runs a bank of digital entropy cells and turns their output into a stream of 32-bit words. Each cell is a pair of inverters. While the shared select line is high the inverters run as two free-running ring oscillators and pick up jitter. While the line is low they are cross-coupled into a bistable latch, which settles through metastability to 0 or 1. The controller drives the select line with a counter-based phase machine. The oscillation and resolve phases each have their own programmable length, counted in clock cycles.

The bit is taken at the clock edge where select goes back high, which is the end of the resolve phase. The replicas of each cell style are first reduced to one bit per style by XOR. A two-level multiplexer then picks the active style. Kept bits are packed MSB-first into a word that leaves on a valid/ready interface. Valid stays high and the word stays unchanged until ready is seen. While a full word is waiting, the next resolve phase cannot start, so the oscillation phase is stretched. No bit is ever dropped because of back-pressure. A free-running counter reports the total number of kept bits, so long sequences can be checked off chip.

The style code and both phase lengths are latched each time an oscillation phase starts. The first bit of a run that starts from idle is discarded. The first bit after any latched change of style or length is also discarded. The enable input starts and stops harvesting.

Top module: `trng_phase_ctrl`

## Requirements
- R1: During and after reset the outputs are as follows: `cell_sel` is 1, `out_valid` is 0, `out_data` is 0, `bit_count` is 0 and `style_err` is 0.
- R2: While `enable` is low and no resolve phase is in progress, `cell_sel` stays 1 and `bit_count` does not change.
- R3: Without back-pressure, an oscillation phase holds `cell_sel` at 1 for exactly `osc_len` cycles. The value is latched when the phase starts, and a value of 0 acts as 1.
- R4: A resolve phase holds `cell_sel` at 0 for exactly `res_len` cycles, using the value latched at the start of the preceding oscillation phase. A value of 0 acts as 1.
- R5: The harvested bit is the XOR of the active style's replica bits, sampled at the clock edge where `cell_sel` returns to 1. Replica r of style s is `cell_bits[s*REPL + r]`.
- R6: Style codes 0 to 8 select a style. Codes 9 to 15 give 0 bits, and `style_err` is 1 while such a code is latched.
- R7: Kept bits shift into the word MSB-first, so the first kept bit lands in `out_data[31]`. `out_valid` rises in the same cycle that the 32nd bit is shifted in.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and no resolve phase begins.
- R9: The first bit after a start from idle is discarded, and so is the first bit after a change of style, `osc_len` or `res_len` latched at an oscillation start. A discarded bit affects neither the word nor `bit_count`.
- R10: `bit_count` rises by one for each kept bit, at the same edge that the bit is shifted in.
- R11: If `enable` falls during a resolve phase, that phase completes and its bit is harvested. If `enable` is low during an oscillation phase, the block returns to idle at the next edge without harvesting a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run/stop for harvesting |
| style_sel | input | SEL_W (4) | Cell style code |
| osc_len | input | LEN_W (8) | Oscillation phase length in cycles |
| res_len | input | LEN_W (8) | Resolve phase length in cycles |
| cell_bits | input | STYLES*REPL (279) | Resolved bits from all cell replicas |
| out_ready | input | 1 | Consumer accepts the word |
| cell_sel | output | 1 | Shared select: 1 oscillate, 0 resolve |
| style_err | output | 1 | Latched style code is out of range |
| out_data | output | WORD_W (32) | Packed random word |
| out_valid | output | 1 | Word is complete and held |
| bit_count | output | CNT_W (32) | Total of kept bits |

## Verification
The assertions take for granted that `cell_bits` reach a settled value before the edge that ends a resolve phase. They also take for granted that the consumer drives `out_ready` as a level that the block samples on the clock edge. The bench changes its inputs only at falling clock edges, which keeps it within both assumptions. It changes the style and the lengths only while a resolve phase is running or while the block is idle. Phase lengths stay between 0 and 5, so every window that the length counters in the checker measure remains short.

// File: rtl/trng_pkg.sv
package trng_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OSC  = 2'd1,
    PH_RES  = 2'd2
  } phase_t;
endpackage

// File: rtl/trng_phase_fsm.sv
module trng_phase_fsm
  import trng_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hold,
  input  logic [LEN_W-1:0] osc_len_i,
  input  logic [LEN_W-1:0] res_len_i,
  output logic             sel_o,
  output logic             cap_o,
  output logic             enter_osc_o,
  output logic             from_idle_o
);
  phase_t           st_q;
  logic [LEN_W-1:0] cnt_q;

  function automatic logic [LEN_W-1:0] last_idx(input logic [LEN_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  always_comb begin
    cap_o       = (st_q == PH_RES) && (cnt_q == '0);
    from_idle_o = (st_q == PH_IDLE);
    enter_osc_o = enable && (from_idle_o || cap_o);
    sel_o       = (st_q != PH_RES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          if (enable) begin
            st_q  <= PH_OSC;
            cnt_q <= last_idx(osc_len_i);
          end
        end
        PH_OSC: begin
          if (!enable) begin
            st_q <= PH_IDLE;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!hold) begin
            st_q  <= PH_RES;
            cnt_q <= last_idx(res_len_i);
          end
        end
        PH_RES: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (enable) begin
            st_q  <= PH_OSC;
            cnt_q <= last_idx(osc_len_i);
          end else begin
            st_q <= PH_IDLE;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trng_style_fold.sv
module trng_style_fold #(
  parameter int STYLES = 9,
  parameter int REPL   = 31
) (
  input  logic [STYLES*REPL-1:0] cells,
  output logic [STYLES-1:0]      folded
);
  for (genvar s = 0; s < STYLES; s++) begin : g_style
    assign folded[s] = ^cells[s*REPL +: REPL];
  end
endmodule

// File: rtl/trng_style_mux.sv
module trng_style_mux #(
  parameter int STYLES = 9,
  parameter int GRP    = 3,
  parameter int SEL_W  = 4
) (
  input  logic [STYLES-1:0] bits,
  input  logic [SEL_W-1:0]  code,
  output logic              bit_o,
  output logic              err_o
);
  localparam int NGRP  = (STYLES + GRP - 1) / GRP;
  localparam int MW    = (GRP > 1) ? $clog2(GRP) : 1;
  localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int MSLOT = 1 << MW;
  localparam int GSLOT = 1 << GW;

  logic [SEL_W-1:0] q_full, r_full;
  logic [MW-1:0]    mem_idx;
  logic [GW-1:0]    grp_idx;
  logic [GSLOT-1:0] grp_out;

  always_comb begin
    q_full  = code / SEL_W'(GRP);
    r_full  = code % SEL_W'(GRP);
    mem_idx = r_full[MW-1:0];
    grp_idx = q_full[GW-1:0];
  end

  // first level: one member picked inside every group
  for (genvar g = 0; g < GSLOT; g++) begin : g_grp
    logic [MSLOT-1:0] slice;
    for (genvar m = 0; m < MSLOT; m++) begin : g_mem
      if ((m < GRP) && (g * GRP + m < STYLES)) begin : g_live
        assign slice[m] = bits[g*GRP+m];
      end else begin : g_pad
        assign slice[m] = 1'b0;
      end
    end
    assign grp_out[g] = slice[mem_idx];
  end

  // second level: one group picked, codes beyond the table give zero
  always_comb begin
    err_o = (code >= SEL_W'(STYLES));
    bit_o = err_o ? 1'b0 : grp_out[grp_idx];
  end
endmodule

// File: rtl/trng_word_pack.sv
module trng_word_pack #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              bit_i,
  input  logic              ready,
  output logic [WORD_W-1:0] data,
  output logic              valid,
  output logic [CNT_W-1:0]  count
);
  localparam int NW = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q;
  logic [NW-1:0]     n_q;
  logic              valid_q;
  logic [CNT_W-1:0]  count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      n_q     <= '0;
      valid_q <= 1'b0;
      count_q <= '0;
    end else begin
      if (valid_q && ready) valid_q <= 1'b0;
      if (push) begin
        sr_q    <= {sr_q[WORD_W-2:0], bit_i};
        count_q <= count_q + 1'b1;
        if (n_q == NW'(WORD_W - 1)) begin
          n_q     <= '0;
          valid_q <= 1'b1;
        end else begin
          n_q <= n_q + 1'b1;
        end
      end
    end
  end

  assign data  = sr_q;
  assign valid = valid_q;
  assign count = count_q;
endmodule

// File: rtl/trng_phase_ctrl.sv
module trng_phase_ctrl #(
  parameter int STYLES = 9,
  parameter int REPL   = 31,
  parameter int GRP    = 3,
  parameter int SEL_W  = 4,
  parameter int LEN_W  = 8,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [SEL_W-1:0]       style_sel,
  input  logic [LEN_W-1:0]       osc_len,
  input  logic [LEN_W-1:0]       res_len,
  input  logic [STYLES*REPL-1:0] cell_bits,
  input  logic                   out_ready,
  output logic                   cell_sel,
  output logic                   style_err,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_valid,
  output logic [CNT_W-1:0]       bit_count
);
  logic [SEL_W-1:0]  sty_q;
  logic [LEN_W-1:0]  osc_q, res_q;
  logic              disc_q;
  logic              cap, enter_osc, from_idle, hold;
  logic [STYLES-1:0] folded;
  logic              pick_bit;

  assign hold = out_valid && !out_ready;

  trng_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold(hold),
    .osc_len_i(osc_len), .res_len_i(res_q),
    .sel_o(cell_sel), .cap_o(cap), .enter_osc_o(enter_osc), .from_idle_o(from_idle)
  );

  // configuration latched at every oscillation start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sty_q  <= '0;
      osc_q  <= '0;
      res_q  <= '0;
      disc_q <= 1'b1;
    end else if (enter_osc) begin
      sty_q  <= style_sel;
      osc_q  <= osc_len;
      res_q  <= res_len;
      disc_q <= from_idle || (style_sel != sty_q) || (osc_len != osc_q) || (res_len != res_q);
    end
  end

  trng_style_fold #(.STYLES(STYLES), .REPL(REPL)) u_fold (
    .cells(cell_bits), .folded(folded)
  );

  trng_style_mux #(.STYLES(STYLES), .GRP(GRP), .SEL_W(SEL_W)) u_mux (
    .bits(folded), .code(sty_q), .bit_o(pick_bit), .err_o(style_err)
  );

  trng_word_pack #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .push(cap && !disc_q), .bit_i(pick_bit),
    .ready(out_ready), .data(out_data), .valid(out_valid), .count(bit_count)
  );
endmodule

// File: rtl/trng_phase_chk.sv
module trng_phase_chk #(
  parameter int LEN_W  = 8,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              cell_sel,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [CNT_W-1:0]  bit_count,
  input logic [LEN_W-1:0]  res_q
);
  logic [LEN_W:0]   low_cnt;
  logic [LEN_W-1:0] res_eff;

  assign res_eff = (res_q == '0) ? LEN_W'(1) : res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (!cell_sel) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && cell_sel) |=> cell_sel);

  p_resolve_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_sel) |-> (low_cnt == {1'b0, $past(res_eff)}));

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_no_resolve_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && cell_sel) |=> cell_sel);

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_count != $past(bit_count)) |-> ((bit_count == $past(bit_count) + 1'b1) && $rose(cell_sel)));
endmodule

bind trng_phase_ctrl trng_phase_chk #(.LEN_W(LEN_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cell_sel(cell_sel),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .bit_count(bit_count), .res_q(res_q)
);

// File: tb/sim_trng_phase_ctrl.sv
module sim_trng_phase_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STYLES = 9;
  localparam int REPL   = 31;
  localparam int NC     = STYLES * REPL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [3:0]    style_sel = '0;
  logic [7:0]    osc_len = '0, res_len = '0;
  logic [NC-1:0] cell_bits = '0;
  logic          out_ready = 1'b0;
  logic          cell_sel, style_err, out_valid;
  logic [31:0]   out_data, bit_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  trng_phase_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .style_sel(style_sel),
    .osc_len(osc_len), .res_len(res_len), .cell_bits(cell_bits), .out_ready(out_ready),
    .cell_sel(cell_sel), .style_err(style_err), .out_data(out_data),
    .out_valid(out_valid), .bit_count(bit_count)
  );

  int checks = 0, fails = 0;

  // reference model state
  logic [3:0]  m_style;
  logic [7:0]  m_osc, m_res;
  logic        m_disc = 1'b1;
  logic [31:0] exp_sr = '0, exp_cnt = '0;
  int          exp_n = 0;
  logic [31:0] q[$];
  logic        sel_prev = 1'b1, run_chk = 1'b0, stall_seen = 1'b0, rise_seen = 1'b0;
  int          low_run = 0, high_run = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] x);
    return (x == 0) ? 1 : int'(x);
  endfunction

  function automatic logic fold(input logic [NC-1:0] c, input logic [3:0] s);
    logic x = 1'b0;
    if (s > 4'd8) return 1'b0;
    for (int r = 0; r < REPL; r++) x ^= c[int'(s)*REPL + r];
    return x;
  endfunction

  task automatic step(input int ready_pct, input int chg_pct);
    logic b, nd, rdy;
    logic [NC-1:0] cv;
    @(negedge clk);
    rise_seen = 1'b0;
    if (!sel_prev && cell_sel) begin
      rise_seen = 1'b1;
      chk(low_run == eff(m_res), "R4", "resolve length", low_run, eff(m_res));
      b = fold(cell_bits, m_style);
      if (!m_disc) begin
        exp_sr = {exp_sr[30:0], b};
        exp_cnt++;
        exp_n++;
        if (exp_n == 32) begin q.push_back(exp_sr); exp_n = 0; end
      end
      chk(bit_count == exp_cnt, "R10", "bit_count", bit_count, exp_cnt);
      if (enable) begin
        nd = (style_sel != m_style) || (osc_len != m_osc) || (res_len != m_res);
        m_style = style_sel; m_osc = osc_len; m_res = res_len; m_disc = nd;
        run_chk = 1'b1;
        chk(style_err == (style_sel > 4'd8), "R6", "style_err", style_err, style_sel > 4'd8);
      end else begin
        run_chk = 1'b0;
      end
      high_run = 1; stall_seen = 1'b0;
    end else if (sel_prev && !cell_sel) begin
      if (run_chk && !stall_seen)
        chk(high_run == eff(m_osc), "R3", "oscillation length", high_run, eff(m_osc));
      low_run = 1;
    end else if (cell_sel) high_run++;
    else low_run++;
    sel_prev = cell_sel;

    rdy = ($urandom_range(99) < ready_pct);
    chk(out_valid == (q.size() != 0), "R7", "out_valid", out_valid, q.size() != 0);
    if (out_valid && rdy && q.size() != 0) begin
      chk(out_data == q[0], "R5/R7/R9", "word", out_data, q[0]);
      void'(q.pop_front());
    end
    if (out_valid && !rdy) stall_seen = 1'b1;
    out_ready = rdy;

    for (int i = 0; i < NC; i++) cv[i] = 1'($urandom_range(1));
    cell_bits = cv;

    if (!cell_sel && enable && ($urandom_range(99) < chg_pct)) begin
      style_sel = 4'($urandom_range(15));
      osc_len = 8'($urandom_range(5));
      res_len = 8'($urandom_range(5));
    end
  endtask

  task automatic start_run(input logic [3:0] s, input logic [7:0] o, input logic [7:0] r);
    style_sel = s; osc_len = o; res_len = r;
    m_style = s; m_osc = o; m_res = r; m_disc = 1'b1; run_chk = 1'b0;
    enable = 1'b1;
  endtask

  task automatic stop_run();
    enable = 1'b0;
    repeat (14) step(100, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] cnt0, dat0;
    int guard;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(cell_sel == 1'b1, "R1", "reset cell_sel", cell_sel, 1);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(out_data == '0, "R1", "reset out_data", out_data, 0);
    chk(bit_count == '0, "R1", "reset bit_count", bit_count, 0);
    chk(style_err == 1'b0, "R1", "reset style_err", style_err, 0);
    rst_n = 1'b1;

    // R2: disabled after reset
    for (int i = 0; i < 20; i++) begin
      step(100, 0);
      chk(cell_sel == 1'b1 && bit_count == '0, "R2", "idle select/count", {cell_sel, bit_count}, {1'b1, 32'h0});
    end

    // R9: first bit of a fresh run is dropped
    start_run(4'd4, 8'd3, 8'd2);
    guard = 0;
    do begin step(100, 0); guard++; end while (!rise_seen && guard < 100);
    chk(bit_count == '0, "R9", "first bit kept", bit_count, 0);
    repeat (700) step(100, 0);

    // random back-pressure and mid-run configuration changes
    repeat (3000) step(60, 5);

    // zero lengths act as one cycle
    stop_run();
    start_run(4'd7, 8'd0, 8'd0);
    repeat (400) step(100, 0);

    // out-of-range style code
    stop_run();
    start_run(4'd12, 8'd2, 8'd1);
    repeat (300) step(100, 0);
    chk(style_err == 1'b1, "R6", "style_err held", style_err, 1);

    // R8: long stall with a full word
    stop_run();
    start_run(4'd0, 8'd1, 8'd2);
    guard = 0;
    do begin step(0, 0); guard++; end while (!out_valid && guard < 2000);
    dat0 = out_data;
    for (int i = 0; i < 200; i++) begin
      step(0, 0);
      chk(cell_sel == 1'b1 && out_data == dat0, "R8", "stall hold", out_data, dat0);
    end
    repeat (300) step(100, 0);

    // R11: enable falls inside a resolve phase
    guard = 0;
    do begin step(100, 0); guard++; end while (cell_sel && guard < 100);
    enable = 1'b0;
    guard = 0;
    do begin step(100, 0); guard++; end while (!rise_seen && guard < 100);
    chk(rise_seen && bit_count == exp_cnt, "R11", "resolve completed", bit_count, exp_cnt);
    cnt0 = bit_count;
    for (int i = 0; i < 30; i++) begin
      step(100, 0);
      chk(cell_sel == 1'b1 && bit_count == cnt0, "R2", "stopped select/count", bit_count, cnt0);
    end

    // R11: enable falls inside an oscillation phase
    start_run(4'd2, 8'd5, 8'd3);
    repeat (2) step(100, 0);
    enable = 1'b0;
    cnt0 = exp_cnt;
    for (int i = 0; i < 20; i++) begin
      step(100, 0);
      chk(cell_sel == 1'b1 && bit_count == cnt0, "R11", "abort oscillation", bit_count, cnt0);
    end

    // mixed random tail
    start_run(4'd1, 8'd2, 8'd3);
    repeat (4000) step(70, 8);
    stop_run();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule